// File: doc/BRIEF.md
# Parallel Dense Layer with Argmax

This block is the fully connected classifier at the end of a fixed-point inference chain. It reads a flattened feature vector of `N` signed values from a memory with a fixed read latency. It multiplies that vector against a weight memory that returns `P` weights per read, one for each output lane. From the sums it forms `C` class scores. Each score is a widened signed sum of products plus a bias. The sum is then shifted back by the fractional width and clamped to the data width.

The classes are handled in groups of `P`. Each group makes one full pass over the input vector. After the last group, a scan over the stored scores finds the largest one and reports its index and value. A start pulse launches a run. `busy` stays high while the run is in progress, and a single-cycle `done` marks the end of the run. The result ports keep their value until the next run begins.

The defaults describe a 10-class layer over a 6272-element input, with one lane.

Top module: `dense_argmax`

## Requirements
- R1: During and straight after reset, `busy`, `done` and `rdEn` are low.
- R2: A `start` sampled high while idle raises `busy` on the next cycle. `busy` then stays high for exactly ceil(C/P)·(N+LAT+1)+C cycles.
- R3: `done` is high for exactly one cycle. That cycle immediately follows the last busy cycle, and `busy` is low during it.
- R4: In each group, reads are issued on N consecutive cycles. `featAddr` counts 0 to N-1, and `wAddr` equals group·N+featAddr. `rdEn` is high only while busy. Read data is consumed LAT cycles after its address.
- R5: Values are two's complement with FRAC fractional bits. A score equals floor((Σ x·w + bias·2^FRAC) / 2^FRAC), taken over the full input vector. The sum uses an accumulator wide enough that it cannot overflow. Lane l of group g produces class g·P+l, and its weight sits in bits [l·DW +: DW] of `wData`. The bias for class c sits in bits [c·DW +: DW] of `biasIn`.
- R6: A score above the largest DW-bit signed value reports that maximum. A score below the smallest reports that minimum.
- R7: `classOut` gives the index of the largest signed score, and `maxScore` gives that score. When scores are equal, the lowest index wins.
- R8: When P does not divide C, the lanes of the last group beyond class C-1 store nothing. Their weights have no effect on the result.
- R9: A `start` that arrives while busy is ignored. The run length and the result are unchanged.
- R10: `classOut` and `maxScore` are valid in the `done` cycle, and they hold steady while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, honoured only when idle |
| biasIn | input | C·DW | Per-class bias values, class c in bits [c·DW +: DW] |
| busy | output | 1 | High while a run is active |
| done | output | 1 | One-cycle completion pulse |
| rdEn | output | 1 | Read strobe for both memories |
| featAddr | output | $clog2(N) | Feature vector index |
| featData | input | DW | Feature value, LAT cycles after its address |
| wAddr | output | $clog2(ceil(C/P)·N) | Weight row address, group·N + index |
| wData | input | P·DW | P lane weights, LAT cycles after their address |
| classOut | output | $clog2(C) | Winning class index |
| maxScore | output | DW | Winning score |

## Verification
If the read-valid tracking or the address counter slips by one position, every score is built from the wrong products. The reported class or score is then wrong at the first `done`. A wrong drain or group count appears as a busy length that differs from the closed-form count, and this shows within a single run. The saturating and tie cases use all-equal and clamped scores. Because of that, a comparison that is not strict, or a sign that is lost, picks a different index at the next `done`.

// File: rtl/dense_argmax_pkg.sv
package dense_argmax_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_DRAIN,
    ST_STORE,
    ST_SCAN
  } dnsState_t;

  typedef struct packed {
    logic clearAcc;
    logic accEn;
    logic storeEn;
    logic scanFirst;
    logic scanEn;
  } dnsStrobe_t;

endpackage

// File: rtl/dense_argmax_ctrl.sv
module dense_argmax_ctrl
  import dense_argmax_pkg::*;
#(
  parameter int C   = 10,
  parameter int P   = 1,
  parameter int N   = 6272,
  parameter int LAT = 1,
  localparam int G   = (C + P - 1) / P,
  localparam int IW  = $clog2(N),
  localparam int GW  = (G > 1) ? $clog2(G) : 1,
  localparam int CW  = $clog2(C),
  localparam int DCW = $clog2(LAT + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          rdEn,
  output logic [IW-1:0] idx,
  output logic [GW-1:0] group,
  output logic [CW-1:0] scanIdx,
  output dnsStrobe_t    strobe
);

  dnsState_t       state;
  logic [DCW-1:0]  drainCnt;
  logic [LAT-1:0]  validPipe;
  logic            doneQ;
  logic            issueNow;

  assign issueNow = (state == ST_ISSUE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      idx       <= '0;
      group     <= '0;
      drainCnt  <= '0;
      scanIdx   <= '0;
      validPipe <= '0;
      doneQ     <= 1'b0;
    end else begin
      doneQ     <= 1'b0;
      validPipe <= (validPipe << 1) | LAT'(issueNow);
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_ISSUE;
          idx   <= '0;
          group <= '0;
        end
        ST_ISSUE: begin
          if (idx == IW'(N - 1)) begin
            state    <= ST_DRAIN;
            drainCnt <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (drainCnt == DCW'(LAT - 1)) state <= ST_STORE;
          else drainCnt <= drainCnt + 1'b1;
        end
        ST_STORE: begin
          if (group == GW'(G - 1)) begin
            state   <= ST_SCAN;
            scanIdx <= '0;
          end else begin
            group <= group + 1'b1;
            idx   <= '0;
            state <= ST_ISSUE;
          end
        end
        ST_SCAN: begin
          if (scanIdx == CW'(C - 1)) begin
            state <= ST_IDLE;
            doneQ <= 1'b1;
          end else begin
            scanIdx <= scanIdx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.storeEn   = (state == ST_STORE);
    strobe.clearAcc  = (state == ST_STORE) || (state == ST_IDLE && start);
    strobe.accEn     = validPipe[LAT-1];
    strobe.scanEn    = (state == ST_SCAN);
    strobe.scanFirst = (state == ST_SCAN) && (scanIdx == '0);
  end

  assign busy = (state != ST_IDLE);
  assign done = doneQ;
  assign rdEn = issueNow;

endmodule

// File: rtl/dense_argmax_dp.sv
module dense_argmax_dp
  import dense_argmax_pkg::*;
#(
  parameter int C    = 10,
  parameter int P    = 1,
  parameter int N    = 6272,
  parameter int DW   = 8,
  parameter int FRAC = 4,
  localparam int G   = (C + P - 1) / P,
  localparam int GW  = (G > 1) ? $clog2(G) : 1,
  localparam int CW  = $clog2(C),
  localparam int AW  = 2 * DW + $clog2(N) + 1,
  localparam int SW  = AW + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dnsStrobe_t           strobe,
  input  logic [GW-1:0]        group,
  input  logic [CW-1:0]        scanIdx,
  input  logic [DW-1:0]        featData,
  input  logic [P*DW-1:0]      wData,
  input  logic [C*DW-1:0]      biasIn,
  output logic [CW-1:0]        classOut,
  output logic signed [DW-1:0] maxScore
);

  localparam logic signed [SW-1:0] MAXV = SW'((2 ** (DW - 1)) - 1);
  localparam logic signed [SW-1:0] MINV = -SW'(2 ** (DW - 1));

  logic signed [AW-1:0] acc       [P];
  logic signed [DW-1:0] laneScore [P];
  logic signed [DW-1:0] score     [C];

  // Each lane owns one wide accumulator and its own scaler.
  for (genvar l = 0; l < P; l++) begin : g_lane
    logic signed [2*DW-1:0] prod;
    logic signed [SW-1:0]   sum;
    logic signed [SW-1:0]   shifted;
    logic signed [DW-1:0]   biasVal;

    assign biasVal = ((group * P + l) < C) ? biasIn[((group * P + l) % C)*DW +: DW] : '0;
    assign prod    = $signed(featData) * $signed(wData[l*DW +: DW]);
    assign sum     = SW'(acc[l]) + (SW'(biasVal) <<< FRAC);
    assign shifted = sum >>> FRAC;

    always_comb begin
      if (shifted > MAXV)      laneScore[l] = MAXV[DW-1:0];
      else if (shifted < MINV) laneScore[l] = MINV[DW-1:0];
      else                     laneScore[l] = shifted[DW-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rstN)               acc[l] <= '0;
      else if (strobe.clearAcc) acc[l] <= '0;
      else if (strobe.accEn)    acc[l] <= acc[l] + AW'(prod);
    end
  end

  // Class c is written only by its own lane in its own group; spare lanes write nothing.
  for (genvar c = 0; c < C; c++) begin : g_score
    always_ff @(posedge clk) begin
      if (!rstN) score[c] <= '0;
      else if (strobe.storeEn && group == GW'(c / P)) score[c] <= laneScore[c % P];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      classOut <= '0;
      maxScore <= '0;
    end else if (strobe.scanFirst) begin
      classOut <= scanIdx;
      maxScore <= score[scanIdx];
    end else if (strobe.scanEn && score[scanIdx] > maxScore) begin
      classOut <= scanIdx;
      maxScore <= score[scanIdx];
    end
  end

endmodule

// File: rtl/dense_argmax.sv
module dense_argmax
  import dense_argmax_pkg::*;
#(
  parameter int C    = 10,
  parameter int P    = 1,
  parameter int N    = 6272,
  parameter int LAT  = 1,
  parameter int DW   = 8,
  parameter int FRAC = 4,
  localparam int G   = (C + P - 1) / P,
  localparam int IW  = $clog2(N),
  localparam int GW  = (G > 1) ? $clog2(G) : 1,
  localparam int CW  = $clog2(C),
  localparam int WAW = $clog2(G * N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [C*DW-1:0]   biasIn,
  output logic              busy,
  output logic              done,
  output logic              rdEn,
  output logic [IW-1:0]     featAddr,
  input  logic [DW-1:0]     featData,
  output logic [WAW-1:0]    wAddr,
  input  logic [P*DW-1:0]   wData,
  output logic [CW-1:0]     classOut,
  output logic [DW-1:0]     maxScore
);

  dnsStrobe_t    strobe;
  logic [IW-1:0] idx;
  logic [GW-1:0] group;
  logic [CW-1:0] scanIdx;

  dense_argmax_ctrl #(.C(C), .P(P), .N(N), .LAT(LAT)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
    .rdEn(rdEn), .idx(idx), .group(group), .scanIdx(scanIdx), .strobe(strobe)
  );

  dense_argmax_dp #(.C(C), .P(P), .N(N), .DW(DW), .FRAC(FRAC)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .group(group), .scanIdx(scanIdx),
    .featData(featData), .wData(wData), .biasIn(biasIn),
    .classOut(classOut), .maxScore(maxScore)
  );

  assign featAddr = idx;
  assign wAddr    = WAW'(group) * WAW'(N) + WAW'(idx);

endmodule

// File: rtl/dense_argmax_chk.sv
module dense_argmax_chk #(
  parameter int C  = 10,
  parameter int IW = 4,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          rdEn,
  input logic [IW-1:0] featAddr,
  input logic [CW-1:0] classOut
);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy);

  // R4
  rd_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN) rdEn |-> busy);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && $past(rdEn) && featAddr != '0) |-> featAddr == $past(featAddr) + 1'b1);

  // R2
  busy_launch_chk: assert property (@(posedge clk) disable iff (!rstN) $rose(busy) |-> $past(start));

  // R7
  class_range_chk: assert property (@(posedge clk) disable iff (!rstN) done |-> classOut < CW'(C));

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !done) |-> $stable(classOut));

endmodule

bind dense_argmax dense_argmax_chk #(.C(C), .IW(IW), .CW(CW)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .rdEn(rdEn), .featAddr(featAddr), .classOut(classOut)
);

// File: tb/dense_argmax_tb_top.sv
module dense_argmax_tb_top;

  localparam int C = 10, P = 3, N = 24, LAT = 2, DW = 8, FRAC = 4;
  localparam int G = (C + P - 1) / P;
  localparam int RUN_CYCLES = G * (N + LAT + 1) + C;   // 118
  localparam int NV = 8;
  // {mode, expected class, expected score}
  localparam int VEC [NV][3] = '{
    '{0, 9, 9}, '{1, 0, 5}, '{2, 4, 48}, '{3, 2, 127},
    '{4, 0, -128}, '{5, 9, -59}, '{6, 3, 1}, '{7, 6, 72}
  };

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [C*DW-1:0] biasIn = '0;
  logic busy, done, rdEn;
  logic [$clog2(N)-1:0] featAddr;
  logic [DW-1:0] featData;
  logic [$clog2(G*N)-1:0] wAddr;
  logic [P*DW-1:0] wData;
  logic [$clog2(C)-1:0] classOut;
  logic [DW-1:0] maxScore;
  int mode = 0, nChecks = 0, nFails = 0;
  logic [$clog2(N)-1:0] fa1, fa2;
  logic [$clog2(G*N)-1:0] wa1, wa2;

  always #10 clk = ~clk;

  dense_argmax #(.C(C), .P(P), .N(N), .LAT(LAT), .DW(DW), .FRAC(FRAC)) dut_i (.*);

  function automatic int featFn(int m, int i);
    case (m)
      2, 5: return 2;
      3, 4: return 127;
      6: return 5;
      7: return i - 12;
      default: return 0;
    endcase
  endfunction

  function automatic int wFn(int m, int c, int i);
    case (m)
      2: return (c == 4) ? 16 : 0;
      3: return (c == 7 || c == 2) ? 127 : 0;
      4: return -128;
      5: return -16;
      6: return (c >= C) ? 100 : 0;
      7: return (c == 6) ? i - 12 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic int biasFn(int m, int c);
    case (m)
      0: return c;
      1: return 5;
      5: return c - 20;
      6: return (c == 3) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  // Memory model with a two-cycle read latency
  always @(posedge clk) begin
    fa1 <= featAddr; fa2 <= fa1;
    wa1 <= wAddr;    wa2 <= wa1;
  end

  always_comb begin
    featData = DW'(featFn(mode, int'(fa2)));
    for (int l = 0; l < P; l++)
      wData[l*DW +: DW] = DW'(wFn(mode, (int'(wa2) / N) * P + l, int'(wa2) % N));
  end

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runOne(input int m, input bit extraStart, output int cycles);
    mode = m;
    for (int c = 0; c < C; c++) biasIn[c*DW +: DW] = DW'(biasFn(m, c));
    cycles = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int k = 0; k < 2000; k++) begin
      if (done) break;
      if (busy) cycles++;
      start = extraStart && (cycles == 20);
      @(negedge clk);
    end
    start = 1'b0;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, RUN_CYCLES);
    end
  endtask

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R1
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 rdEn", rdEn, 0);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    check("R1 busy after release", busy, 0);

    // Table: R5 R6 R7 R8 scores and classes, R2 R3 timing
    for (int v = 0; v < NV; v++) begin
      runOne(VEC[v][0], 1'b0, cyc);
      check("R2 busy length", cyc, RUN_CYCLES);
      check("R7 class", int'(classOut), VEC[v][1]);
      check("R5/R6 score", int'($signed(maxScore)), VEC[v][2]);
      check("R3 done busy low", busy, 0);
      @(negedge clk);
      check("R3 done single", done, 0);
    end

    // R9: start mid-run is ignored
    runOne(2, 1'b1, cyc);
    check("R9 busy length", cyc, RUN_CYCLES);
    check("R9 class", int'(classOut), 4);
    @(negedge clk);
    check("R9 no relaunch", busy, 0);

    // R10: result holds while idle
    repeat (5) @(negedge clk);
    check("R10 class held", int'(classOut), 4);
    check("R10 score held", int'($signed(maxScore)), 48);

    // R8: spare lane weights huge, still class 3
    runOne(6, 1'b0, cyc);
    check("R8 class", int'(classOut), 3);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #2000000;
    nChecks++; nFails++;
    $display("FAIL watchdog global actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule